// File: doc/BRIEF.md
# Receive Character Queue with Error Tagging

This block is the holding queue between a serial receiver and the bus side of a UART channel. Every character the receiver finishes is written in together with three error flags: break seen, framing error and parity error. The flags move through the queue with their character. The reader therefore always sees the data and the quality of the oldest unread character together.

Two status views are available, chosen by a mode input. In per-character mode the status shows the flags of the entry at the head, so it changes on each pop. In block mode the status is a sticky OR of the flags of every character accepted since the last reset-error command. In block mode software can read a whole burst and then ask one question about its quality. A push into a full queue is lost and raises a sticky overrun flag. The reset-error command clears that flag as well.

Top module: `rx_status_fifo`

## Requirements
- R1: Each entry holds 8 data bits and 3 flags. Entries leave in the order they were accepted. `head_data_o` shows the data of the oldest entry, and shows zero when the queue is empty.
- R2: The queue holds 16 entries. `count_o` gives the occupancy. `empty_o` is high exactly at count 0 and `full_o` is high exactly at count 16.
- R3: `char_len_i` selects the character length at push time: 0 for 5 bits, 1 for 6, 2 for 7, 3 for 8. Data bits at or above the selected length are stored as zero.
- R4: With `block_mode_i` low, `status_o` gives the head entry's flags as {break, framing, parity} in bits 2, 1 and 0. It changes on every pop and reads zero when the queue is empty.
- R5: With `block_mode_i` high, `status_o` is the bitwise OR of the flags of all pushes accepted since the last reset-error command. Pops do not change it.
- R6: A reset-error command is `cmd_valid_i` high with `cmd_i` equal to 4'h4. It clears the accumulated flags and the overrun flag. A push accepted in the same cycle is still accumulated. Any other command code leaves both unchanged.
- R7: A push while `full_o` is high is dropped, leaves the queue contents unchanged, and sets `overrun_o`. `overrun_o` stays set until a reset-error command.
- R8: A pop while the queue is empty is ignored. The count and the read order are unaffected.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full keep the count unchanged. On a full queue the pop is taken, the push is dropped and the count falls by one.
- R10: After reset the queue is empty with count 0, status 0 and overrun 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write one received character |
| push_data_i | input | 8 | Received character, LSB first bit |
| push_brk_i | input | 1 | Break seen on this character |
| push_frm_i | input | 1 | Framing error on this character |
| push_par_i | input | 1 | Parity error on this character |
| pop_i | input | 1 | Remove the head entry |
| char_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| block_mode_i | input | 1 | 1 = accumulated status, 0 = head status |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code, 4'h4 = reset error |
| head_data_o | output | 8 | Data of the head entry |
| status_o | output | 3 | {break, framing, parity} per the selected mode |
| overrun_o | output | 1 | Sticky lost-push flag |
| full_o | output | 1 | Queue holds 16 entries |
| empty_o | output | 1 | Queue holds no entries |
| count_o | output | 5 | Number of stored entries |

## Verification
The assertions check on every cycle that the count never exceeds the depth and that a push into a full queue leaves it full. They also check that an empty pop leaves the read pointer still, that a balanced push and pop holds the count, and that the accumulated flags only ever gain bits until a clear. After a clear they must be zero, and a dropped push must raise overrun. The bench scenarios cover what a single-cycle property cannot show. These are the end-to-end order and content of characters, the length masking, the head status that follows each pop, and the block status outliving pops. The bench also shows that a non-matching command code leaves the sticky state alone.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  localparam int DATA_W   = 8;
  localparam int LEN_W    = 2;
  localparam int MIN_BITS = 5;
  localparam int CMD_W    = 4;
  localparam logic [CMD_W-1:0] CMD_CLR_ERR = 4'h4;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  typedef struct packed {
    rx_flags_t          flags;
    logic [DATA_W-1:0]  data;
  } rx_entry_t;
endpackage

// File: rtl/rxsf_pack.sv
module rxsf_pack
  import rxsf_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  rx_flags_t         flags_i,
  input  logic [LEN_W-1:0]  len_i,
  output rx_entry_t         entry_o
);
  logic [DATA_W-1:0] masked;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    if (k < MIN_BITS) begin : g_always
      assign masked[k] = data_i[k];
    end else begin : g_cond
      assign masked[k] = data_i[k] & (len_i >= LEN_W'(k - MIN_BITS + 1));
    end
  end

  assign entry_o.data  = masked;
  assign entry_o.flags = flags_i;

  // R3: nothing at or above the selected length reaches storage
  always_comb begin
    if (!$isunknown({data_i, len_i})) begin
      p_mask_r3: assert ((entry_o.data >> (MIN_BITS + int'(len_i))) == '0);
    end
  end
endmodule

// File: rtl/rxsf_store.sv
module rxsf_store
  import rxsf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  rx_entry_t        wr_entry_i,
  output rx_entry_t        head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             drop_o
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             push_ok, pop_ok;
  logic [DEPTH-1:0] slot_we;
  rx_entry_t        slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_we[i] = push_ok && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we[i]) slot_q[i] <= wr_entry_i;
    end
  end

  assign head_o    = empty_o ? '0 : slot_q[rd_ptr_q];
  assign count_o   = count_q;
  assign push_ok_o = push_ok;
  assign drop_o    = push_i && full_o;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (count_q == CNT_W'(DEPTH)));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> ($stable(rd_ptr_q) && count_q == '0));
  p_balanced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o && !full_o) |=> $stable(count_q));
endmodule

// File: rtl/rxsf_status.sv
module rxsf_status
  import rxsf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      block_mode_i,
  input  logic      clr_i,
  input  logic      push_ok_i,
  input  logic      drop_i,
  input  rx_flags_t push_flags_i,
  input  rx_flags_t head_flags_i,
  output rx_flags_t status_o,
  output logic      overrun_o
);
  logic [2:0] acc_q, acc_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    acc_d = clr_i ? '0 : acc_q;
    ovr_d = clr_i ? 1'b0 : ovr_q;
    if (push_ok_i) acc_d = acc_d | push_flags_i;
    if (drop_i)    ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovr_q <= ovr_d;
    end
  end

  assign status_o  = block_mode_i ? rx_flags_t'(acc_q) : head_flags_i;
  assign overrun_o = ovr_q;

  p_acc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((acc_q | $past(acc_q)) == acc_q));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !push_ok_i && !drop_i) |=> (acc_q == '0 && !ovr_q));
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> ovr_q);
  p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_i) |=> ovr_q);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxsf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  input  logic              push_brk_i,
  input  logic              push_frm_i,
  input  logic              push_par_i,
  input  logic              pop_i,
  input  logic [1:0]        char_len_i,
  input  logic              block_mode_i,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  output logic [7:0]        head_data_o,
  output logic [2:0]        status_o,
  output logic              overrun_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  rx_flags_t in_flags;
  rx_flags_t stat;
  rx_entry_t wr_entry, head;
  logic      push_ok, drop, clr_err;

  assign in_flags = '{brk: push_brk_i, frm: push_frm_i, par: push_par_i};
  assign clr_err  = cmd_valid_i && (cmd_i == CMD_CLR_ERR);

  rxsf_pack u_pack (
    .data_i  (push_data_i),
    .flags_i (in_flags),
    .len_i   (char_len_i),
    .entry_o (wr_entry)
  );

  rxsf_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .wr_entry_i (wr_entry),
    .head_o     (head),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .count_o    (count_o),
    .push_ok_o  (push_ok),
    .drop_o     (drop)
  );

  rxsf_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .block_mode_i (block_mode_i),
    .clr_i        (clr_err),
    .push_ok_i    (push_ok),
    .drop_i       (drop),
    .push_flags_i (in_flags),
    .head_flags_i (head.flags),
    .status_o     (stat),
    .overrun_o    (overrun_o)
  );

  assign head_data_o = head.data;
  assign status_o    = stat;
endmodule

// File: tb/rx_status_fifo_test.sv
`timescale 1ns/100ps
module rx_status_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i, pop_i, brk, frm, par, blk, cv;
  logic [7:0] din;
  logic [1:0] len;
  logic [3:0] cmd;
  logic [7:0] head_data_o;
  logic [2:0] status_o;
  logic       overrun_o, full_o, empty_o;
  logic [4:0] count_o;

  int nchk = 0;
  int nerr = 0;
  logic [10:0] mq[$];
  logic [2:0]  macc = '0;
  logic        movr = 1'b0;

  always #2.5 clk = ~clk;

  rx_status_fifo uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(din),
    .push_brk_i(brk), .push_frm_i(frm), .push_par_i(par), .pop_i(pop_i),
    .char_len_i(len), .block_mode_i(blk), .cmd_valid_i(cv), .cmd_i(cmd),
    .head_data_o(head_data_o), .status_o(status_o), .overrun_o(overrun_o),
    .full_o(full_o), .empty_o(empty_o), .count_o(count_o)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update and monitor comparison
  task automatic cycle(input logic p, input logic [7:0] d, input logic [2:0] f,
                       input logic po, input logic c_v, input logic [3:0] c);
    logic p_ok, po_ok;
    push_i = p; din = d; {brk, frm, par} = f; pop_i = po; cv = c_v; cmd = c;
    #1;
    if (po && mq.size() > 0) begin
      check(head_data_o, mq[0][7:0], "R1 head data before pop");
      if (!blk) check(status_o, mq[0][10:8], "R4 head status before pop");
    end
    p_ok  = p && mq.size() < 16;
    po_ok = po && mq.size() > 0;
    @(posedge clk);
    if (c_v && c == 4'h4) begin macc = '0; movr = 1'b0; end
    if (p && !p_ok) movr = 1'b1;
    if (p_ok) macc = macc | f;
    if (po_ok) void'(mq.pop_front());
    if (p_ok) mq.push_back({f, d & (8'hFF >> (3 - len))});
    #1;
    check(count_o, mq.size(), "R2 count");
    check(empty_o, mq.size() == 0, "R2 empty");
    check(full_o, mq.size() == 16, "R2 full");
    check(overrun_o, movr, "R7 overrun");
    if (blk) check(status_o, macc, "R5 block status");
    else     check(status_o, mq.size() == 0 ? 3'b0 : mq[0][10:8], "R4 head status");
    check(head_data_o, mq.size() == 0 ? 8'h0 : mq[0][7:0], "R1 head data");
    push_i = 0; pop_i = 0; cv = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; push_i = 0; pop_i = 0; din = 0; {brk, frm, par} = 0;
    len = 2'd3; blk = 0; cv = 0; cmd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(count_o, 0, "R10 reset count");
    check(empty_o, 1, "R10 reset empty");
    check(status_o, 0, "R10 reset status");
    check(overrun_o, 0, "R10 reset overrun");
    rst_n = 1;
    @(negedge clk);

    // R1 R4: order and head status
    cycle(1, 8'hA1, 3'b001, 0, 0, 0);
    cycle(1, 8'hB2, 3'b010, 0, 0, 0);
    cycle(1, 8'hC3, 3'b100, 0, 0, 0);
    repeat (3) cycle(0, 0, 0, 1, 0, 0);

    // R3: length masking
    for (int l = 0; l < 4; l++) begin
      len = l[1:0];
      cycle(1, 8'hFF, 3'b000, 0, 0, 0);
    end
    len = 2'd3;
    check(head_data_o, 8'h1F, "R3 5-bit masked");
    repeat (4) cycle(0, 0, 0, 1, 0, 0);

    // R2 R7 R9: fill, overflow, full push+pop
    for (int i = 0; i < 16; i++) cycle(1, 8'(i + 16), 3'(i), 0, 0, 0);
    check(full_o, 1, "R2 full at 16");
    cycle(1, 8'hEE, 3'b111, 0, 0, 0);
    check(overrun_o, 1, "R7 overrun set on full push");
    cycle(1, 8'hDD, 3'b000, 1, 0, 0);
    check(count_o, 15, "R9 full push+pop drops push");
    cycle(0, 0, 0, 0, 1, 4'h3);
    check(overrun_o, 1, "R6 other code keeps overrun");
    cycle(0, 0, 0, 0, 1, 4'h4);
    check(overrun_o, 0, "R6 clear overrun");
    repeat (15) cycle(0, 0, 0, 1, 0, 0);

    // R8: empty pop ignored
    cycle(0, 0, 0, 1, 0, 0);
    check(count_o, 0, "R8 empty pop count");
    cycle(1, 8'h5A, 3'b000, 1, 0, 0);
    check(head_data_o, 8'h5A, "R8 order after empty pop");
    // R9: balanced push/pop
    cycle(1, 8'h6B, 3'b000, 0, 0, 0);
    cycle(1, 8'h7C, 3'b000, 1, 0, 0);
    check(count_o, 2, "R9 balanced count");
    repeat (2) cycle(0, 0, 0, 1, 0, 0);

    // R5 R6: block mode
    blk = 1;
    cycle(1, 8'h01, 3'b001, 0, 0, 0);
    cycle(1, 8'h02, 3'b100, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    check(status_o, 3'b101, "R5 block status survives pop");
    cycle(0, 0, 0, 0, 1, 4'h3);
    check(status_o, 3'b101, "R6 other code keeps status");
    cycle(1, 8'h03, 3'b010, 0, 1, 4'h4);
    check(status_o, 3'b010, "R6 clear with same-cycle push");
    cycle(0, 0, 0, 0, 1, 4'h4);
    check(status_o, 3'b000, "R6 clear");
    blk = 0;
    #1;
    check(status_o, 3'b100, "R4 head status after mode switch");
    repeat (2) cycle(0, 0, 0, 1, 0, 0);

    summary();
    $finish;
  end
endmodule